// File: doc/BRIEF.md
# Start-Up Reset and Memory Initialization Sequencer

This block manages device start-up after a power-on reset or after a software-driven reset. It owns a small configuration register on the host register bus. That register holds a level-sensitive software reset bit, a stop bit, an operating-mode field and a read-only initialization status bit. When an initialization starts, the block sends a one-cycle start pulse to every RAM-based module. It then combines their busy flags into a single registered initialization-in-progress status.

While initialization is running, the block sits between the host strobe bus and the downstream register file. Every write is dropped and flagged with an access error. Every read of an address other than the configuration register returns zero and never reaches the downstream file. The data interfaces are held idle while the software reset bit is set, while the stop bit is set, or while initialization runs. The host bus itself stays usable throughout, so software can poll the status bit and then bring the device up: clear the software reset bit, clear the stop bit, then program the mode.

Top module: `isq_top`

## Requirements
- R1: After power-on reset the configuration register holds soft reset 0, stop 1 and mode 0, `init_busy` is 1, and in the first cycle after reset release `mod_start` pulses high on every bit for exactly one cycle.
- R2: A 0-to-1 change of the soft reset bit produces exactly one one-cycle start pulse on all `mod_start` bits, issued the cycle after the bit is set; holding the bit at 1 produces no further pulses.
- R3: Every `if_idle` bit is 1 while the soft reset bit is 1, while the stop bit is 1, or while initialization is in progress; otherwise every bit is 0.
- R4: `init_busy` is 1 from reset (or from the start pulse) while any `mod_busy` bit is 1, and it falls exactly one clock after the last `mod_busy` bit falls.
- R5: While initialization is in progress, a read of any address other than the configuration address returns 0 on `hb_rdata` and does not assert `dn_rd`.
- R6: While initialization is in progress, every write, including one to the configuration address, is ignored, and `hb_err` is 1 for the cycle after the write strobe.
- R7: The configuration register at address `CFG_ADDR` (default 0) can be read at any time: bit 0 soft reset, bit 1 stop, bit 2 initialization in progress (read-only), bits 3 and up the mode field; unused upper bits read 0. Read data appears on `hb_rdata` with `hb_rvalid` one cycle after the read strobe.
- R8: A write to the mode field takes effect only if the stop bit was already 0 before that write; a single write that clears stop and sets the mode leaves the mode unchanged.
- R9: Once initialization has finished, writes to other addresses are passed to `dn_wr`/`dn_addr`/`dn_wdata` in the strobe cycle, reads return the downstream data one cycle later, and `hb_err` stays 0.
- R10: Clearing the soft reset bit (1 to 0) starts no initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_addr | input | ADDR_W | Host register address |
| hb_wdata | input | DATA_W | Host write data |
| hb_rdata | output | DATA_W | Host read data, registered |
| hb_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| hb_err | output | 1 | Write attempted while initialization was in progress |
| dn_wr | output | 1 | Write strobe passed to the downstream registers |
| dn_rd | output | 1 | Read strobe passed to the downstream registers |
| dn_addr | output | ADDR_W | Downstream address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdata | input | DATA_W | Downstream read data, valid in the strobe cycle |
| mod_start | output | NUM_MOD | One-cycle initialization start pulse per module |
| mod_busy | input | NUM_MOD | Per-module initialization-in-progress flag |
| init_busy | output | 1 | Combined initialization-in-progress status |
| if_idle | output | NUM_IF | Force-idle request per data interface |
| op_mode | output | MODE_W | Current operating-mode field |

## Verification
The combined busy status is exercised with per-module completion times drawn at random, so that the last module to finish differs from run to run. This tells a true OR of all flags apart from one that follows a single module or clears too early or too late. Accesses are tried on both sides of the initialization window: downstream reads, downstream writes and configuration writes. This separates blocked traffic from forwarded traffic and shows that a blocked write leaves both the register file and the configuration unchanged. The soft reset bit is driven through set, held, blocked-clear and clear. This tells an edge-triggered start apart from a level-triggered one. Mode writes with the stop bit already clear and with it still set show the ordering rule.

// File: rtl/isq_pkg.sv
package isq_pkg;
   // configuration register field positions (software relies on these)
   localparam int unsigned SRST_BIT = 0;
   localparam int unsigned STOP_BIT = 1;
   localparam int unsigned IIP_BIT  = 2;
   localparam int unsigned MODE_LSB = 3;

   // classification of one host access
   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_CFG_RD,
      ACC_CFG_WR,
      ACC_DN_RD,
      ACC_DN_WR,
      ACC_BLK_RD,
      ACC_BLK_WR
   } acc_kind_e;
endpackage

// File: rtl/isq_start_ctrl.sv
module isq_start_ctrl #(
   parameter int unsigned NUM_MOD = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               srst_q,
   output logic [NUM_MOD-1:0] start_o,
   output logic               kick_o,
   output logic               start_any_o
);
   logic kick_q;
   logic srst_prev_q;
   logic start_q;

   // kick_q is set by power-on reset and launches the first sequence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick_q      <= 1'b1;
         srst_prev_q <= 1'b0;
         start_q     <= 1'b0;
      end else begin
         kick_q      <= 1'b0;
         srst_prev_q <= srst_q;
         start_q     <= kick_q | (srst_q & ~srst_prev_q);
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_MOD; gi++) begin : g_start
         assign start_o[gi] = start_q;
      end
   endgenerate

   assign kick_o      = kick_q;
   assign start_any_o = start_q;

   // R2
   // one_pulse_chk
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);

   // R10
   // no_start_on_clear_chk
   no_start_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(srst_q) && !kick_q) |=> !start_q);
endmodule

// File: rtl/isq_busy_merge.sv
module isq_busy_merge #(
   parameter int unsigned NUM_MOD     = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kick_i,
   input  logic               start_i,
   input  logic [NUM_MOD-1:0] busy_i,
   output logic               iip_o
);
   logic [NUM_MOD-1:0] busy_s;
   logic               iip_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign busy_s = busy_i;
      end else begin : g_sync
         logic [NUM_MOD-1:0] pipe_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) pipe_q[s] <= '0;
            end else begin
               pipe_q[0] <= busy_i;
               for (int s = 1; s < SYNC_STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            end
         end
         assign busy_s = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   // status covers the gap between the start pulse and the modules' busy flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) iip_q <= 1'b1;
      else        iip_q <= kick_i | start_i | (|busy_s);
   end

   assign iip_o = iip_q;

   // R4
   // busy_hold_chk
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|busy_s) |=> iip_q);

   // R4
   // busy_clear_chk
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_s == '0 && !start_i && !kick_i) |=> !iip_q);
endmodule

// File: rtl/isq_cfg_reg.sv
module isq_cfg_reg
   import isq_pkg::*;
#(
   parameter int unsigned MODE_W = 4,
   localparam int unsigned CFG_W = MODE_LSB + MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_W-1:0]  wdata,
   output logic              srst_q,
   output logic              stop_q,
   output logic [MODE_W-1:0] mode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         stop_q <= 1'b1;
         mode_q <= '0;
      end else if (wr_en) begin
         srst_q <= wdata[SRST_BIT];
         stop_q <= wdata[STOP_BIT];
         // mode only accepted once stop has already been cleared
         if (!stop_q) mode_q <= wdata[MODE_LSB +: MODE_W];
      end
   end

   // R8
   // mode_locked_chk
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |=> $stable(mode_q));
endmodule

// File: rtl/isq_access_gate.sv
module isq_access_gate
   import isq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CFG_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_i,
   input  logic              hb_wr,
   input  logic              hb_rd,
   input  logic [ADDR_W-1:0] hb_addr,
   input  logic [DATA_W-1:0] hb_wdata,
   input  logic [DATA_W-1:0] cfg_rdata,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic              cfg_wr,
   output logic              dn_wr,
   output logic              dn_rd,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   output logic [DATA_W-1:0] hb_rdata,
   output logic              hb_rvalid,
   output logic              hb_err
);
   acc_kind_e kind;
   logic      cfg_hit;

   assign cfg_hit = (hb_addr == ADDR_W'(CFG_ADDR));

   always_comb begin
      kind = ACC_NONE;
      if (hb_wr) begin
         if (blk_i)        kind = ACC_BLK_WR;
         else if (cfg_hit) kind = ACC_CFG_WR;
         else              kind = ACC_DN_WR;
      end else if (hb_rd) begin
         if (cfg_hit)      kind = ACC_CFG_RD;
         else if (blk_i)   kind = ACC_BLK_RD;
         else              kind = ACC_DN_RD;
      end
   end

   assign cfg_wr   = (kind == ACC_CFG_WR);
   assign dn_wr    = (kind == ACC_DN_WR);
   assign dn_rd    = (kind == ACC_DN_RD);
   assign dn_addr  = hb_addr;
   assign dn_wdata = hb_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hb_rdata  <= '0;
         hb_rvalid <= 1'b0;
         hb_err    <= 1'b0;
      end else begin
         hb_rvalid <= (kind == ACC_CFG_RD) | (kind == ACC_DN_RD) | (kind == ACC_BLK_RD);
         hb_err    <= (kind == ACC_BLK_WR);
         unique case (kind)
            ACC_CFG_RD: hb_rdata <= cfg_rdata;
            ACC_DN_RD:  hb_rdata <= dn_rdata;
            ACC_BLK_RD: hb_rdata <= '0;
            default:    hb_rdata <= hb_rdata;
         endcase
      end
   end

   // R6
   // blocked_write_err_chk
   blocked_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_wr && blk_i) |=> hb_err);

   // R7
   // read_valid_chk
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_rd && !hb_wr) |=> hb_rvalid);
endmodule

// File: rtl/isq_top.sv
module isq_top
   import isq_pkg::*;
#(
   parameter int unsigned NUM_MOD     = 4,
   parameter int unsigned NUM_IF      = 3,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned MODE_W      = 4,
   parameter int unsigned CFG_ADDR    = 0,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hb_wr,
   input  logic               hb_rd,
   input  logic [ADDR_W-1:0]  hb_addr,
   input  logic [DATA_W-1:0]  hb_wdata,
   output logic [DATA_W-1:0]  hb_rdata,
   output logic               hb_rvalid,
   output logic               hb_err,
   output logic               dn_wr,
   output logic               dn_rd,
   output logic [ADDR_W-1:0]  dn_addr,
   output logic [DATA_W-1:0]  dn_wdata,
   input  logic [DATA_W-1:0]  dn_rdata,
   output logic [NUM_MOD-1:0] mod_start,
   input  logic [NUM_MOD-1:0] mod_busy,
   output logic               init_busy,
   output logic [NUM_IF-1:0]  if_idle,
   output logic [MODE_W-1:0]  op_mode
);
   localparam int unsigned CFG_W = MODE_LSB + MODE_W;

   generate
      if (NUM_MOD < 1)                begin : g_bad_mod  $error("NUM_MOD must be at least 1"); end
      if (NUM_IF < 1)                 begin : g_bad_if   $error("NUM_IF must be at least 1"); end
      if (DATA_W < CFG_W)             begin : g_bad_data $error("DATA_W too narrow for config"); end
      if (CFG_ADDR >= (1 << ADDR_W))  begin : g_bad_addr $error("CFG_ADDR out of range"); end
   endgenerate

   logic              srst_q, stop_q, kick, start_any, iip, blk, cfg_wr;
   logic [MODE_W-1:0] mode_q;
   logic [DATA_W-1:0] cfg_rdata;

   isq_start_ctrl #(.NUM_MOD(NUM_MOD)) u_start (
      .clk(clk), .rst_n(rst_n), .srst_q(srst_q),
      .start_o(mod_start), .kick_o(kick), .start_any_o(start_any)
   );

   isq_busy_merge #(.NUM_MOD(NUM_MOD), .SYNC_STAGES(SYNC_STAGES)) u_merge (
      .clk(clk), .rst_n(rst_n), .kick_i(kick), .start_i(start_any),
      .busy_i(mod_busy), .iip_o(iip)
   );

   assign blk = iip | start_any | kick;

   isq_cfg_reg #(.MODE_W(MODE_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(hb_wdata[CFG_W-1:0]),
      .srst_q(srst_q), .stop_q(stop_q), .mode_q(mode_q)
   );

   always_comb begin
      cfg_rdata                        = '0;
      cfg_rdata[SRST_BIT]              = srst_q;
      cfg_rdata[STOP_BIT]              = stop_q;
      cfg_rdata[IIP_BIT]               = iip;
      cfg_rdata[MODE_LSB +: MODE_W]    = mode_q;
   end

   isq_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_gate (
      .clk(clk), .rst_n(rst_n), .blk_i(blk),
      .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
      .cfg_rdata(cfg_rdata), .dn_rdata(dn_rdata), .cfg_wr(cfg_wr),
      .dn_wr(dn_wr), .dn_rd(dn_rd), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
      .hb_rdata(hb_rdata), .hb_rvalid(hb_rvalid), .hb_err(hb_err)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IF; gi++) begin : g_idle
         assign if_idle[gi] = srst_q | stop_q | blk;
      end
   endgenerate

   assign init_busy = iip;
   assign op_mode   = mode_q;

   // R5
   // blocked_no_downstream_chk
   blocked_no_downstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk |-> (!dn_wr && !dn_rd));

   // R3
   // idle_on_srst_chk
   idle_on_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_q || stop_q) |-> (&if_idle));

   // R1
   // start_all_same_chk
   start_all_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_start == '0) || (&mod_start));
endmodule

// File: tb/isq_top_bench.sv
module isq_top_bench;
   localparam int NM = 4;
   localparam int NI = 3;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int MW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          hb_wr = 0, hb_rd = 0;
   logic [AW-1:0] hb_addr = '0;
   logic [DW-1:0] hb_wdata = '0;
   logic [DW-1:0] hb_rdata, dn_wdata, dn_rdata;
   logic          hb_rvalid, hb_err, dn_wr, dn_rd, init_busy;
   logic [AW-1:0] dn_addr;
   logic [NM-1:0] mod_start, mod_busy;
   logic [NI-1:0] if_idle;
   logic [MW-1:0] op_mode;

   isq_top u_isq_top (
      .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr),
      .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_rvalid(hb_rvalid), .hb_err(hb_err),
      .dn_wr(dn_wr), .dn_rd(dn_rd), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
      .dn_rdata(dn_rdata), .mod_start(mod_start), .mod_busy(mod_busy),
      .init_busy(init_busy), .if_idle(if_idle), .op_mode(op_mode)
   );

   int checks = 0;
   int errors = 0;

   // downstream register file model
   logic [DW-1:0] mem [16];
   assign dn_rdata = mem[dn_addr[3:0]];
   always @(posedge clk) if (dn_wr) mem[dn_addr[3:0]] <= dn_wdata;

   // module busy models with random completion times
   int cnt [NM];
   int lat [NM];
   for (genvar g = 0; g < NM; g++) begin : g_mod
      always @(posedge clk) begin
         if (!rst_n) cnt[g] <= 0;
         else if (mod_start[g]) cnt[g] <= lat[g];
         else if (cnt[g] != 0) cnt[g] <= cnt[g] - 1;
      end
      assign mod_busy[g] = (cnt[g] != 0);
   end

   int  start_cnt = 0;
   int  dn_rd_blocked = 0;
   always @(posedge clk) begin
      if (rst_n && mod_start[0]) start_cnt++;
      if (rst_n && dn_rd && init_busy) dn_rd_blocked++;
   end

   task automatic check(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pick_latencies();
      for (int i = 0; i < NM; i++) lat[i] = 12 + int'($urandom % 30);
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); hb_wr = 1; hb_addr = a; hb_wdata = d;
      @(negedge clk); hb_wr = 0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk); hb_rd = 1; hb_addr = a;
      @(negedge clk); hb_rd = 0; d = hb_rdata;
      check(hb_rvalid === 1'b1, "R7 rvalid", hb_rvalid, 1);
   endtask

   task automatic wait_init_done(input string tag);
      while (mod_busy == '0) @(negedge clk);
      while (mod_busy != '0) @(negedge clk);
      check(init_busy === 1'b1, {"R4 busy held one cycle ", tag}, init_busy, 1);
      @(negedge clk);
      check(init_busy === 1'b0, {"R4 busy clears ", tag}, init_busy, 0);
   endtask

   task automatic t_power_on();
      logic [DW-1:0] d;
      pick_latencies();
      for (int i = 0; i < 16; i++) mem[i] = DW'(16'h1100 + i);
      mem[3] = 16'hA5A5;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      check(init_busy === 1'b1, "R1 busy at reset", init_busy, 1);
      check(&if_idle, "R3 idle at reset", if_idle, 3'b111);
      check(mod_start === '0, "R1 no start before edge", mod_start, 0);
      @(negedge clk);
      check(mod_start === '1, "R1 start pulse", mod_start, 4'hF);
      @(negedge clk);
      check(mod_start === '0, "R1 start one cycle", mod_start, 0);
      bus_read(0, d);
      check(d === 16'h0006, "R7 cfg during init", d, 16'h0006);
      check(op_mode === '0, "R1 mode zero", op_mode, 0);
      bus_read(3, d);
      check(d === '0, "R5 blocked read zero", d, 0);
      bus_write(3, 16'h1234);
      check(hb_err === 1'b1, "R6 err on blocked write", hb_err, 1);
      wait_init_done("por");
      check(dn_rd_blocked == 0, "R5 no dn_rd while blocked", dn_rd_blocked, 0);
      check(start_cnt == 1, "R1 single start", start_cnt, 1);
   endtask

   task automatic t_normal_access();
      logic [DW-1:0] d;
      bus_read(3, d);
      check(d === 16'hA5A5, "R6 blocked write ignored", d, 16'hA5A5);
      bus_write(5, 16'h00C3);
      check(hb_err === 1'b0, "R9 no err", hb_err, 0);
      check(mem[5] === 16'h00C3, "R9 write forwarded", mem[5], 16'h00C3);
      bus_read(5, d);
      check(d === 16'h00C3, "R9 read back", d, 16'h00C3);
   endtask

   task automatic t_mode_order();
      logic [DW-1:0] d;
      bus_write(0, 16'h0028);
      bus_read(0, d);
      check(d === 16'h0000, "R8 mode ignored while stop", d, 0);
      check(if_idle === '0, "R3 idle released", if_idle, 0);
      bus_write(0, 16'h0028);
      check(op_mode === 4'd5, "R8 mode set", op_mode, 5);
      bus_read(0, d);
      check(d === 16'h0028, "R7 cfg layout", d, 16'h0028);
   endtask

   task automatic t_soft_reset();
      logic [DW-1:0] d;
      int base;
      pick_latencies();
      base = start_cnt;
      bus_write(0, 16'h0029);
      check(&if_idle, "R3 idle on srst", if_idle, 3'b111);
      @(negedge clk);
      bus_write(0, 16'h0028);
      check(hb_err === 1'b1, "R6 cfg write blocked", hb_err, 1);
      wait_init_done("srst");
      repeat (5) @(negedge clk);
      check(start_cnt == base + 1, "R2 one start on level", start_cnt, base + 1);
      check(&if_idle, "R3 idle while srst held", if_idle, 3'b111);
      bus_read(0, d);
      check(d === 16'h0029, "R6 srst survived blocked clear", d, 16'h0029);
      bus_write(0, 16'h0028);
      repeat (4) @(negedge clk);
      check(start_cnt == base + 1, "R10 no start on clear", start_cnt, base + 1);
      check(init_busy === 1'b0, "R10 stays idle status", init_busy, 0);
      check(if_idle === '0, "R3 idle released after clear", if_idle, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_power_on();
      t_normal_access();
      t_mode_order();
      t_soft_reset();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule